// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block lays a 32 by 32 pixel, two-colour cursor over a stream of 24-bit pixels. Software programs the cursor through a 32-bit register window. One packed register holds the cursor's column and row. Two banks of 32 words give the cursor's shape, one word per cursor row. A word in the enable bank says which pixels of that row are opaque. The word with the same row number in the colour-select bank chooses which of two overlay colours each opaque pixel takes. Both words are scanned from the most significant bit, left to right across the row.

On the pixel side, a timing generator presents the coordinates of each pixel, a valid flag and the pixel from the frame memory. The two overlay colours come from an external palette. One clock later the block returns the same pixel, or the cursor colour where the cursor is opaque, together with a delayed copy of the valid flag. After reset the cursor is parked far outside the visible area, so nothing is drawn until software moves it.

Top module: `cursor_overlay`

## Requirements
- R1: A write to byte offset 0x8FC loads the cursor column from write data bits 31:16 and the cursor row from bits 15:0.
- R2: A write to offset 0x900 + 4*r (r = 0..31) loads the enable word of cursor row r. A write to offset 0x980 + 4*r loads the colour-select word of cursor row r.
- R3: Offset 0x818 is a general register. It reads back the last value written to it, with bit 25 always forced to 1. It holds zero after reset, so it then reads 0x0200_0000.
- R4: A read of any offset other than 0x818 returns zero, including the position, enable and colour-select offsets.
- R5: The cursor covers screen row y only when cursY <= y < cursY+32 and y < SCREEN_H. It then uses cursor row y-cursY.
- R6: Within a covered row, screen column cursX+i (i = 0..31) uses bit 31-i of that row's enable and colour-select words.
- R7: Nothing is drawn at any column >= SCREEN_W, and nothing at all is drawn while cursX >= SCREEN_W.
- R8: A covered pixel whose enable bit is 1 outputs colour_hi when its colour-select bit is 1 and colour_lo when it is 0.
- R9: Every other pixel passes through unchanged from pix_in.
- R10: Reset sets cursor column and row to 0xF000 and clears both shape banks, so no pixel is replaced after reset.
- R11: The pixel path has exactly one clock of latency. out_valid is pix_valid delayed one clock and is 0 after reset. Register writes take effect for pixels presented in the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset in the register window |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| colour_lo | input | 24 | Overlay colour used where the select bit is 0 |
| colour_hi | input | 24 | Overlay colour used where the select bit is 1 |
| pix_valid | input | 1 | Pixel input valid |
| pix_x | input | 16 | Screen column of the input pixel |
| pix_y | input | 16 | Screen row of the input pixel |
| pix_in | input | 24 | Underlying pixel |
| out_valid | output | 1 | Output valid, one clock after pix_valid |
| out_pix | output | 24 | Merged pixel |

## Verification
The assertions run on every cycle. They check the one-clock valid delay, the read data rules for the general register and for all other offsets, and that the output always holds the passed pixel or one of the two overlay colours. They also check that pixels at or beyond the screen width, or seen while the cursor column is off-screen, pass through. The bench's frame scans carry the rest, and only they can show it: the exact shape placement, the MSB-first bit order, the row index decode in both banks, the clipping at the right and bottom edges, and the parked position after reset. A behavioural model predicts each of these pixel by pixel.

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
  parameter int SCREEN_W = 64,
  parameter int SCREEN_H = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [23:0] colour_lo,
  input  logic [23:0] colour_hi,
  input  logic        pix_valid,
  input  logic [15:0] pix_x,
  input  logic [15:0] pix_y,
  input  logic [23:0] pix_in,
  output logic        out_valid,
  output logic [23:0] out_pix
);
  localparam int          CUR_DIM  = 32;
  localparam logic [15:0] W_LIM    = 16'(SCREEN_W);
  localparam logic [15:0] H_LIM    = 16'(SCREEN_H);
  localparam logic [15:0] PARK     = 16'hF000;
  localparam logic [11:0] OFS_POS  = 12'h8FC;
  localparam logic [11:0] OFS_MISC = 12'h818;
  localparam logic [4:0]  SEL_EN   = 5'b10010;
  localparam logic [4:0]  SEL_COL  = 5'b10011;
  localparam logic [31:0] MISC_ONE = 32'h0200_0000;

  logic [15:0] cur_x, cur_y;
  logic [31:0] misc_q;
  logic [CUR_DIM-1:0] en_word  [CUR_DIM];
  logic [CUR_DIM-1:0] col_word [CUR_DIM];

  wire [4:0] wr_row = reg_addr[6:2];
  wire       wr_en_bank  = reg_we && reg_addr[11:7] == SEL_EN;
  wire       wr_col_bank = reg_we && reg_addr[11:7] == SEL_COL;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_x  <= PARK;
      cur_y  <= PARK;
      misc_q <= '0;
      for (int r = 0; r < CUR_DIM; r++) begin
        en_word[r]  <= '0;
        col_word[r] <= '0;
      end
    end else begin
      if (reg_we && reg_addr == OFS_POS) begin
        cur_x <= reg_wdata[31:16];
        cur_y <= reg_wdata[15:0];
      end
      if (reg_we && reg_addr == OFS_MISC) misc_q <= reg_wdata;
      if (wr_en_bank)  en_word[wr_row]  <= reg_wdata;
      if (wr_col_bank) col_word[wr_row] <= reg_wdata;
    end
  end

  assign reg_rdata = (reg_addr == OFS_MISC) ? (misc_q | MISC_ONE) : '0;

  wire [16:0] y_end = {1'b0, cur_y} + 17'd32;
  wire [16:0] x_end = {1'b0, cur_x} + 17'd32;
  wire        in_rows = pix_y >= cur_y && {1'b0, pix_y} < y_end && pix_y < H_LIM;
  wire        in_cols = pix_x >= cur_x && {1'b0, pix_x} < x_end && pix_x < W_LIM
                        && cur_x < W_LIM;
  wire [15:0] dy_full = pix_y - cur_y;
  wire [15:0] dx_full = pix_x - cur_x;
  wire [4:0]  row_sel = dy_full[4:0];
  wire [4:0]  bit_sel = 5'd31 - dx_full[4:0];
  wire        opaque  = in_rows && in_cols && en_word[row_sel][bit_sel];
  wire        pick_hi = col_word[row_sel][bit_sel];
  wire [23:0] merged  = opaque ? (pick_hi ? colour_hi : colour_lo) : pix_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else begin
      out_valid <= pix_valid;
      out_pix   <= merged;
    end
  end
endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
  parameter int SCREEN_W = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] reg_addr,
  input logic [31:0] reg_rdata,
  input logic [23:0] colour_lo,
  input logic [23:0] colour_hi,
  input logic        pix_valid,
  input logic [15:0] pix_x,
  input logic [23:0] pix_in,
  input logic        out_valid,
  input logic [23:0] out_pix,
  input logic [15:0] cur_x
);
  localparam logic [15:0] W_LIM = 16'(SCREEN_W);

  AST_VALID_ON: assert property (@(posedge clk) disable iff (!rst_n) pix_valid |=> out_valid); // R11
  AST_VALID_OFF: assert property (@(posedge clk) disable iff (!rst_n) !pix_valid |=> !out_valid); // R11
  AST_MISC_BIT: assert property (@(posedge clk) disable iff (!rst_n) reg_addr == 12'h818 |-> reg_rdata[25]); // R3
  AST_OTHER_ZERO: assert property (@(posedge clk) disable iff (!rst_n) reg_addr != 12'h818 |-> reg_rdata == 32'd0); // R4
  AST_CLIP_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && (pix_x >= W_LIM || cur_x >= W_LIM)) |=> out_pix == $past(pix_in)); // R7
  AST_COLOUR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> (out_pix == $past(pix_in) || out_pix == $past(colour_lo) || out_pix == $past(colour_hi))); // R8
endmodule

bind cursor_overlay cursor_overlay_chk #(.SCREEN_W(SCREEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .colour_lo(colour_lo), .colour_hi(colour_hi), .pix_valid(pix_valid),
  .pix_x(pix_x), .pix_in(pix_in), .out_valid(out_valid), .out_pix(out_pix),
  .cur_x(cur_x)
);

// File: tb/cursor_overlay_bench.sv
`timescale 1ns/1ps
module cursor_overlay_bench;
  localparam int W = 64;
  localparam int H = 48;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [23:0] colour_lo = 24'h10_20_30;
  logic [23:0] colour_hi = 24'hE0_D0_C0;
  logic        pix_valid = 0;
  logic [15:0] pix_x = 0, pix_y = 0;
  logic [23:0] pix_in = 0;
  logic        out_valid;
  logic [23:0] out_pix;

  always #5 clk = ~clk;

  cursor_overlay #(.SCREEN_W(W), .SCREEN_H(H)) u_cursor_overlay (.*);

  int checks = 0, fails = 0;
  string tag = "R10";

  // behavioural model state
  int          m_cx = 'hF000, m_cy = 'hF000;
  logic [31:0] m_misc = 0;
  logic [31:0] m_en  [32];
  logic [31:0] m_col [32];
  logic        e_valid = 0;
  logic [23:0] e_pix = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      e_valid = 0; e_pix = 0;
      m_cx = 'hF000; m_cy = 'hF000; m_misc = 0;
      for (int r = 0; r < 32; r++) begin m_en[r] = 0; m_col[r] = 0; end
    end else begin
      int dx, dy;
      dx = int'(pix_x) - m_cx;
      dy = int'(pix_y) - m_cy;
      e_valid = pix_valid;
      e_pix = pix_in;
      if (dx >= 0 && dx < 32 && dy >= 0 && dy < 32 && int'(pix_x) < W && int'(pix_y) < H
          && m_cx < W && m_en[dy][31-dx])
        e_pix = m_col[dy][31-dx] ? colour_hi : colour_lo;
      if (reg_we) begin
        if (reg_addr == 12'h8FC) begin m_cx = int'(reg_wdata[31:16]); m_cy = int'(reg_wdata[15:0]); end
        if (reg_addr == 12'h818) m_misc = reg_wdata;
        if (reg_addr >= 12'h900 && reg_addr < 12'h980) m_en[(reg_addr - 12'h900) / 4] = reg_wdata;
        if (reg_addr >= 12'h980 && reg_addr < 12'hA00) m_col[(reg_addr - 12'h980) / 4] = reg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (out_valid !== e_valid || (e_valid && out_pix !== e_pix)) begin
        fails++;
        $display("FAIL %s pixel: valid=%0b pix=%06h expected valid=%0b pix=%06h", tag, out_valid, out_pix, e_valid, e_pix);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #2;
    reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string t);
    @(posedge clk); #2;
    reg_addr = a;
    #1;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s read %03h: got %08h expected %08h", t, a, reg_rdata, exp);
    end
  endtask

  task automatic scan(input int xmax);
    int n = 0;
    for (int y = 0; y < H + 2; y++)
      for (int x = 0; x < xmax; x++) begin
        @(posedge clk); #2;
        n++;
        pix_valid = (n % 7) != 0;
        pix_x = 16'(x); pix_y = 16'(y);
        pix_in = {8'(x * 3), 8'(y * 5), 8'(n)};
      end
    @(posedge clk); #2;
    pix_valid = 0;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    checks++;
    if (out_valid !== 1'b0) begin
      fails++; $display("FAIL R11 reset out_valid=%0b expected 0", out_valid);
    end
    tag = "R3";
    rd(12'h818, 32'h0200_0000, "R3 reset");
    wr(12'h818, 32'h0000_00FF);
    rd(12'h818, 32'h0200_00FF, "R3 readback");
    tag = "R4";
    rd(12'h8FC, 0, "R4 position");
    rd(12'h900, 0, "R4 enable bank");
    rd(12'h984, 0, "R4 select bank");
    rd(12'h000, 0, "R4 unused");
    // R10: shape loaded but cursor parked
    for (int r = 0; r < 32; r++) wr(12'(12'h900 + 4 * r), 32'hFFFF_FFFF);
    rd(12'h900, 0, "R4 after enable write");
    tag = "R10";
    scan(W);
    // R2 R6 R8 R9: varied shape
    for (int r = 0; r < 32; r++) begin
      wr(12'(12'h900 + 4 * r), 32'hF0F0_3C3C ^ (32'h1 << r) ^ (32'h8000_0000 >> r));
      wr(12'(12'h980 + 4 * r), 32'hAAAA_5555 ^ {r[7:0], 24'h0} ^ 32'(r * 9));
    end
    wr(12'h97C, 32'h8000_0001);
    wr(12'h9FC, 32'h8000_0000);
    tag = "R1 R5 R6 R8 R9";
    wr(12'h8FC, {16'd5, 16'd3});
    scan(W);
    tag = "R7 right clip";
    wr(12'h8FC, {16'd50, 16'd10});
    scan(W + 8);
    tag = "R7 column off-screen";
    wr(12'h8FC, {16'(W), 16'd0});
    scan(W + 4);
    tag = "R5 bottom clip";
    wr(12'h8FC, {16'd0, 16'(H - 6)});
    scan(W);
    tag = "R11 write during stream";
    wr(12'h8FC, {16'd20, 16'd20});
    scan(40);
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule